// File: doc/BRIEF.md
# Two-Pass Index Generator for Factored DFT Lengths

This block sequences one recursive DFT kernel through an N-point transform that has been split into two passes of shorter transforms over a two-bank data memory. The length is factored as N = c·m. In the first pass the kernel runs m transforms of c points. Each reads its inputs from bank 0 and writes its intermediate results to bank 1. In the second pass it runs c transforms of m points. Each reads back from bank 1 and writes the final spectrum into bank 0 in natural order. Reads and writes are never issued in the same cycle.

Seven lengths are supported. When c and m share no factor, the block uses a prime-factor index map and no twiddle factors arise. When N is a power of a single prime, it uses a common-factor map. On every first-pass write it then raises a twiddle request together with the exponent that the kernel must apply. All modular index arithmetic is done by addition followed by at most one subtraction of N. The arithmetic of the transform itself lies outside this block.

Top module: `pfcf_index_gen`

## Requirements
- R1: `len_sel` selects the length at start. The codes map as follows as (N, c, m): 0 = (288, 32, 9), 1 = (256, 16, 16), 2 = (176, 16, 11), 3 = (112, 16, 7), 4 = (27, 9, 3), 5 = (480, 32, 15), 6 = (60, 12, 5). Codes 1 and 4 use the common-factor map and the rest use the prime-factor map. An accepted run issues exactly 4·N address cycles.
- R2: A start taken while idle with a valid code puts the first read on the outputs in the next cycle. In pass 0 (`pass` = 0), for each row r = 0..m-1, c read cycles come first, then c write cycles. `row` shows r and `elem` counts 0..c-1 within each phase. `rd_en` and `wr_en` are never high together.
- R3: Address format: bit 9 is the bank and bits 8:0 are the index. A pass-0 read goes to bank 0 at index (m·e + c·r) mod N for prime-factor lengths, or at m·e + r for common-factor lengths, where e = `elem` and r = `row`.
- R4: A pass-0 write goes to bank 1 at index e + c·r.
- R5: In pass 1 (`pass` = 1), for each row r = 0..c-1, m reads come first, then m writes. Each read goes to bank 1 at index r + c·e.
- R6: A pass-1 write goes to bank 0. For prime-factor lengths the index k is the unique value below N with k mod c = r and k mod m = e. For common-factor lengths the index is r + c·e.
- R7: `tw_req` is high exactly on pass-0 writes of common-factor lengths, and `tw_exp` then equals (r·e) mod N. At all other times both `tw_req` and `tw_exp` are zero.
- R8: `done` is high for exactly one cycle, in the cycle after the last pass-1 write, with both enables low. `busy` is low in the cycle after that.
- R9: A start with code 7 raises `err` for exactly one cycle, in the next cycle. No address is issued and `busy` stays low.
- R10: A start that arrives while `busy` is high is ignored, and the running sequence continues unchanged.
- R11: During and right after reset, all outputs are zero.
- R12: Within each pass, every index 0..N-1 is read exactly once and written exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transform at the selected length |
| len_sel | input | 3 | Length code |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | One-cycle pulse for an unsupported code |
| done | output | 1 | One-cycle pulse after the last write |
| rd_en | output | 1 | Read address valid |
| rd_addr | output | 10 | Read address (bank, index) |
| wr_en | output | 1 | Write address valid |
| wr_addr | output | 10 | Write address (bank, index) |
| pass | output | 1 | Current pass |
| row | output | 6 | Sub-transform number within the pass |
| elem | output | 6 | Element number within the phase |
| tw_req | output | 1 | Twiddle multiplication needed on this write |
| tw_exp | output | 9 | Twiddle exponent modulo N |

## Verification
Every supported length is swept in full, and each cycle is compared against indices that the bench computes arithmetically. For the output map, the bench finds the index by a residue search instead of using the multiplier constants. This separates a wrong map constant from a wrong step order, and a per-pass occupancy count catches any index that is duplicated or missed. The two common-factor lengths exercise the twiddle exponent, including the row-0 case where it must stay zero. The prime-factor lengths show that the request stays low. A start injected mid-run, followed by a bad code and then a fresh run, tells apart ignoring a start from restarting on it, and rejecting a code from merely flagging it.

// File: rtl/pfcf_pkg.sv
package pfcf_pkg;
  localparam int IDX_W = 9;
  localparam int FAC_W = 6;
  localparam int SEL_W = 3;
  localparam int ADDR_W = IDX_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_DONE} seq_st_t;

  typedef struct packed {
    logic             ok;
    logic             cf;
    logic [IDX_W-1:0] len;
    logic [IDX_W-1:0] ka;
    logic [IDX_W-1:0] kb;
    logic [IDX_W-1:0] kc;
    logic [IDX_W-1:0] kd;
    logic [FAC_W-1:0] fc;
    logic [FAC_W-1:0] fm;
  } map_cfg_t;

  function automatic map_cfg_t mk_cfg(input int n, input int c, input int m,
                                      input int a, input int b, input int cc,
                                      input int d, input bit cf);
    map_cfg_t r;
    r.ok  = 1'b1;
    r.cf  = cf;
    r.len = IDX_W'(n);
    r.ka  = IDX_W'(a);
    r.kb  = IDX_W'(b);
    r.kc  = IDX_W'(cc);
    r.kd  = IDX_W'(d);
    r.fc  = FAC_W'(c);
    r.fm  = FAC_W'(m);
    return r;
  endfunction

  // Input steps (ka per element, kb per row); output steps (kc per row, kd per element).
  function automatic map_cfg_t map_lookup(input logic [SEL_W-1:0] code);
    map_cfg_t r;
    case (code)
      3'd0:    r = mk_cfg(288, 32,  9,  9, 32, 225,  64, 1'b0);
      3'd1:    r = mk_cfg(256, 16, 16, 16,  1,   1,  16, 1'b1);
      3'd2:    r = mk_cfg(176, 16, 11, 11, 16,  33, 144, 1'b0);
      3'd3:    r = mk_cfg(112, 16,  7,  7, 16,  49,  64, 1'b0);
      3'd4:    r = mk_cfg( 27,  9,  3,  3,  1,   1,   9, 1'b1);
      3'd5:    r = mk_cfg(480, 32, 15, 15, 32, 225, 256, 1'b0);
      3'd6:    r = mk_cfg( 60, 12,  5,  5, 12,  25,  36, 1'b0);
      default: r = '0;
    endcase
    return r;
  endfunction

  // Modular add with one conditional subtract; both operands below n.
  function automatic logic [IDX_W-1:0] mod_add(input logic [IDX_W-1:0] x,
                                               input logic [IDX_W-1:0] y,
                                               input logic [IDX_W-1:0] n);
    logic [IDX_W:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    return s[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/pfcf_cfg_reg.sv
module pfcf_cfg_reg
  import pfcf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             load,
  output logic             sel_ok,
  output map_cfg_t         cfg
);
  map_cfg_t sel_cfg;
  assign sel_cfg = map_lookup(sel);
  assign sel_ok  = sel_cfg.ok;

  always_ff @(posedge clk) begin
    if (!rst_n)    cfg <= '0;
    else if (load) cfg <= sel_cfg;
  end

  assert_cfg_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cfg.ok && (cfg.len == IDX_W'(cfg.fc) * IDX_W'(cfg.fm))));
endmodule

// File: rtl/pfcf_mod_acc.sv
module pfcf_mod_acc
  import pfcf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             row_step,
  input  logic             el_step,
  input  logic [IDX_W-1:0] row_inc,
  input  logic [IDX_W-1:0] el_inc,
  input  logic [IDX_W-1:0] modn,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] base;
  logic [IDX_W-1:0] next_base;
  assign next_base = mod_add(base, row_inc, modn);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      base <= '0;
      idx  <= '0;
    end else if (row_step) begin
      base <= next_base;
      idx  <= next_base;
    end else if (el_step) begin
      idx <= mod_add(idx, el_inc, modn);
    end
  end

  assert_idx_below_len_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (modn != '0) |-> (idx < modn));
endmodule

// File: rtl/pfcf_seq.sv
module pfcf_seq
  import pfcf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [FAC_W-1:0] fc,
  input  logic [FAC_W-1:0] fm,
  output logic             busy,
  output logic             rd_on,
  output logic             wr_on,
  output logic             done,
  output logic             pass,
  output logic [FAC_W-1:0] row,
  output logic [FAC_W-1:0] elem,
  output logic             ev_row_end,
  output logic             ev_pass_end
);
  seq_st_t          st;
  logic [FAC_W-1:0] rows_n;
  logic [FAC_W-1:0] len_n;
  logic             last_el;
  logic             last_row;

  assign rows_n      = pass ? fc : fm;
  assign len_n       = pass ? fm : fc;
  assign last_el     = (elem == len_n - FAC_W'(1));
  assign last_row    = (row == rows_n - FAC_W'(1));
  assign ev_row_end  = (st == ST_WR) && last_el && !last_row;
  assign ev_pass_end = (st == ST_WR) && last_el && last_row && !pass;

  assign busy  = (st != ST_IDLE);
  assign rd_on = (st == ST_RD);
  assign wr_on = (st == ST_WR);
  assign done  = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      pass <= 1'b0;
      row  <= '0;
      elem <= '0;
    end else begin
      case (st)
        ST_IDLE: if (go) begin
          st   <= ST_RD;
          pass <= 1'b0;
          row  <= '0;
          elem <= '0;
        end
        ST_RD: begin
          if (last_el) begin
            st   <= ST_WR;
            elem <= '0;
          end else begin
            elem <= elem + FAC_W'(1);
          end
        end
        ST_WR: begin
          if (last_el) begin
            elem <= '0;
            if (!last_row) begin
              row <= row + FAC_W'(1);
              st  <= ST_RD;
            end else if (!pass) begin
              pass <= 1'b1;
              row  <= '0;
              st   <= ST_RD;
            end else begin
              st <= ST_DONE;
            end
          end else begin
            elem <= elem + FAC_W'(1);
          end
        end
        default: begin
          st   <= ST_IDLE;
          pass <= 1'b0;
          row  <= '0;
        end
      endcase
    end
  end

  assert_counters_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_on || wr_on) |-> (row < rows_n && elem < len_n));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));
endmodule

// File: rtl/pfcf_index_gen.sv
module pfcf_index_gen
  import pfcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEL_W-1:0]  len_sel,
  output logic              busy,
  output logic              err,
  output logic              done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              pass,
  output logic [FAC_W-1:0]  row,
  output logic [FAC_W-1:0]  elem,
  output logic              tw_req,
  output logic [IDX_W-1:0]  tw_exp
);
  map_cfg_t         cfg;
  logic             sel_ok;
  logic             go;
  logic             ev_row_end;
  logic             ev_pass_end;
  logic             acc_clear;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_row_inc;
  logic [IDX_W-1:0] rd_el_inc;
  logic [IDX_W-1:0] wr_row_inc;
  logic [IDX_W-1:0] wr_el_inc;
  logic [IDX_W-1:0] tw_acc;
  logic             err_q;

  assign go        = start && !busy && sel_ok;
  assign acc_clear = go || ev_pass_end;

  // Pass 0: input map on reads, linear intermediate on writes; pass 1 the reverse.
  assign rd_el_inc  = pass ? IDX_W'(cfg.fc) : cfg.ka;
  assign rd_row_inc = pass ? IDX_W'(1)      : cfg.kb;
  assign wr_el_inc  = pass ? cfg.kd         : IDX_W'(1);
  assign wr_row_inc = pass ? cfg.kc         : IDX_W'(cfg.fc);

  pfcf_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .sel(len_sel), .load(go), .sel_ok(sel_ok), .cfg(cfg)
  );

  pfcf_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .fc(cfg.fc), .fm(cfg.fm),
    .busy(busy), .rd_on(rd_en), .wr_on(wr_en), .done(done), .pass(pass),
    .row(row), .elem(elem), .ev_row_end(ev_row_end), .ev_pass_end(ev_pass_end)
  );

  pfcf_mod_acc u_rd_acc (
    .clk(clk), .rst_n(rst_n), .clear(acc_clear), .row_step(ev_row_end),
    .el_step(rd_en), .row_inc(rd_row_inc), .el_inc(rd_el_inc),
    .modn(cfg.len), .idx(rd_idx)
  );

  pfcf_mod_acc u_wr_acc (
    .clk(clk), .rst_n(rst_n), .clear(acc_clear), .row_step(ev_row_end),
    .el_step(wr_en), .row_inc(wr_row_inc), .el_inc(wr_el_inc),
    .modn(cfg.len), .idx(wr_idx)
  );

  // Twiddle exponent grows by the row number on each pass-0 write.
  always_ff @(posedge clk) begin
    if (!rst_n || go || ev_row_end) tw_acc <= '0;
    else if (wr_en && !pass)        tw_acc <= mod_add(tw_acc, IDX_W'(row), cfg.len);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= start && !busy && !sel_ok;
  end

  assign err     = err_q;
  assign rd_addr = rd_en ? {pass, rd_idx} : '0;
  assign wr_addr = wr_en ? {!pass, wr_idx} : '0;
  assign tw_req  = wr_en && !pass && cfg.cf;
  assign tw_exp  = tw_req ? tw_acc : '0;

  assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (rd_en && rd_addr == '0 && !pass));
  assert_one_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_en, wr_en, done}));
  assert_tw_cf_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tw_req |-> (cfg.cf && cfg.ok && !pass && wr_en));
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !rd_en && !wr_en && !done));
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(cfg));
endmodule

// File: tb/test_pfcf_index_gen.sv
module test_pfcf_index_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [2:0] len_sel;
  logic       busy, err, done, rd_en, wr_en, pass, tw_req;
  logic [9:0] rd_addr, wr_addr;
  logic [5:0] row, elem;
  logic [8:0] tw_exp;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  int tn[7]  = '{288, 256, 176, 112, 27, 480, 60};
  int tc[7]  = '{32, 16, 16, 16, 9, 32, 12};
  int tm[7]  = '{9, 16, 11, 7, 3, 15, 5};
  bit tcf[7] = '{0, 1, 0, 0, 1, 0, 0};

  int cntr[512];
  int cntw[512];

  always #(CLK_PERIOD/2) clk = ~clk;

  pfcf_index_gen i_pfcf_index_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .len_sel(len_sel),
    .busy(busy), .err(err), .done(done), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .pass(pass), .row(row), .elem(elem),
    .tw_req(tw_req), .tw_exp(tw_exp)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int crt_index(input int n, input int c, input int m,
                                   input int k1, input int k2);
    for (int k = 0; k < n; k++)
      if (k % c == k1 && k % m == k2) return k;
    return -1;
  endfunction

  task automatic run_len(input int code, input int inj);
    int n, c, m, rows, len, cyc, exp_addr, act_addr, exp_tw, ctr;
    bit cf, exp_twreq, ok;
    n = tn[code]; c = tc[code]; m = tm[code]; cf = tcf[code];
    @(negedge clk); len_sel = 3'(code); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    for (int p = 0; p < 2; p++) begin
      rows = p ? c : m;
      len  = p ? m : c;
      for (int i = 0; i < 512; i++) begin cntr[i] = 0; cntw[i] = 0; end
      for (int r = 0; r < rows; r++) begin
        for (int ph = 0; ph < 2; ph++) begin
          for (int e = 0; e < len; e++) begin
            // R2 / R5: schedule and counters
            ok = busy && (rd_en == (ph == 0)) && (wr_en == (ph == 1)) &&
                 (pass == p[0]) && (int'(row) == r) && (int'(elem) == e);
            chk(ok, p ? "R5 schedule" : "R2 schedule",
                int'(pass)*4096 + int'(row)*64 + int'(elem), p*4096 + r*64 + e);
            if (p == 0 && ph == 0)      exp_addr = cf ? (m*e + r) : ((m*e + c*r) % n);
            else if (p == 0)            exp_addr = 512 + e + c*r;
            else if (ph == 0)           exp_addr = 512 + r + c*e;
            else                        exp_addr = cf ? (r + c*e) : crt_index(n, c, m, r, e);
            act_addr = ph ? int'(wr_addr) : int'(rd_addr);
            chk(act_addr == exp_addr,
                (p == 0) ? (ph ? "R4 addr" : "R3 addr") : (ph ? "R6 addr" : "R5 addr"),
                act_addr, exp_addr);
            exp_twreq = cf && p == 0 && ph == 1;
            exp_tw    = exp_twreq ? ((r*e) % n) : 0;
            chk(tw_req == exp_twreq && int'(tw_exp) == exp_tw, "R7 twiddle",
                int'(tw_req)*1024 + int'(tw_exp), int'(exp_twreq)*1024 + exp_tw);
            if (ph == 0) cntr[act_addr % 512]++;
            else         cntw[act_addr % 512]++;
            start = (cyc == inj);
            if (cyc == inj) len_sel = 3'd5;
            cyc++;
            @(negedge clk);
          end
        end
      end
      // R12: each index exactly once per pass
      ctr = 0;
      for (int i = 0; i < n; i++) if (cntr[i] == 1 && cntw[i] == 1) ctr++;
      chk(ctr == n, "R12 coverage", ctr, n);
    end
    start = 1'b0;
    chk(cyc == 4*n, "R1 cycle total", cyc, 4*n);
    chk(done && !rd_en && !wr_en, "R8 done pulse", int'(done), 1);
    @(negedge clk);
    chk(!done && !busy, "R8 idle after done", int'(done)*2 + int'(busy), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; len_sel = 3'd0;
    repeat (3) @(negedge clk);
    chk(!busy && !err && !done && !rd_en && !wr_en && rd_addr == 0 && wr_addr == 0 &&
        !tw_req && tw_exp == 0 && !pass && row == 0 && elem == 0,
        "R11 reset outputs", int'(busy) + int'(rd_en) + int'(wr_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_en && !wr_en && !done, "R11 idle after reset", int'(busy), 0);

    for (int code = 0; code < 7; code++)
      run_len(code, (code == 2) ? 100 : -1);   // R10: start injected during code 2

    // R9: unsupported code
    @(negedge clk); len_sel = 3'd7; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(err && !busy && !rd_en && !wr_en, "R9 err pulse", int'(err)*2 + int'(busy), 2);
    @(negedge clk);
    chk(!err && !busy && !rd_en, "R9 err single", int'(err)*2 + int'(busy), 0);
    run_len(4, -1);                            // R9: recovery after rejection

    $display("Result: errors=%0d of %0d checks", errs, checks);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule